// File: doc/BRIEF.md
# Display-List Coprocessor Instruction Sequencer

This block walks a list of two-word instructions held in memory and acts on them in step with the video beam. It reads instruction words over a simple request/data memory port. A read is only requested in odd memory slots, so the block leaves every even slot free for the display and other fixed-slot fetchers. Each word fetch presents a fixed marker register address on the register-write output. The exception is the second word of a register move, which presents the move's own destination together with a one-cycle write strobe and the data word.

There are three operations. A register move writes an immediate word to a register. A beam wait parks the sequencer off the bus until an external beam comparator reports a match. A conditional skip asks the comparator once and, on a match, steps over the following instruction. While an instruction is parked on the comparator, the sequencer exposes the position and mask fields of that instruction to the comparator.

A bank of location registers holds jump targets. A jump strobe copies the matching register into the program counter and abandons the current instruction. A vertical-blank pulse reloads the program counter from location register 0. After reset the sequencer does nothing until its DMA enable is set. Software is expected to strobe a jump first, so that the start address is known.

Top module: `dlist_seq`

## Requirements
- R1: After reset, and whenever `dma_en` is low, `mem_req` and `reg_we` stay low.
- R2: `mem_req` is asserted only in odd slots and never in two adjacent cycles. Slots are counted from reset release, and the first clock edge after release opens slot 1.
- R3: A first word with bit 0 = 0 is a register move. A first word with bit 0 = 1 is a beam test, and bit 0 of the second word then selects wait (0) or skip (1).
- R4: For a move, `reg_we` pulses for exactly one cycle during the second-word fetch. In that cycle `reg_addr` is first-word bits 8..1 with bit 0 forced to 0, and `reg_wdata` is the second word. Bits 15..9 of the first word have no effect on the address.
- R5: Every fetch other than a move's second word drives `reg_addr` = 0x08C.
- R6: The program counter advances by 2 per fetched word. Back-to-back moves write exactly 4 cycles apart.
- R7: In a wait, no fetch is made while `cond_met` is low. During the wait `cmp_valid` is high, `cmp_pos` carries first-word bits 15..1 and `cmp_mask` carries second-word bits 15..1. Once `cond_met` is seen high, execution resumes with the next instruction.
- R8: A skip whose condition is met steps over the following two-word instruction.
- R9: A skip whose condition is not met continues with the following instruction.
- R10: Strobe `jmp[i]` loads location register i into the program counter, aborting any instruction in progress, including a wait. When several strobes coincide, the lowest index wins.
- R11: A `vblank` pulse loads location register 0 into the program counter.
- R12: Fetch addresses are always even. Bit 0 of a location register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one memory slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Allows instruction fetches |
| mem_req | output | 1 | Memory read request for the current slot |
| mem_addr | output | 18 | Byte address of the requested word |
| mem_rdata | input | 16 | Word returned in the same slot |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 9 | Register address (marker or move destination) |
| reg_wdata | output | 16 | Register write data |
| lc_wr | input | 2 | Per-register load enables for location registers |
| lc_wdata | input | 18 | Value loaded into a location register |
| jmp | input | 2 | Jump strobes, one per location register |
| vblank | input | 1 | Vertical-blank start pulse |
| cmp_valid | output | 1 | A beam test is waiting on the comparator |
| cmp_pos | output | 15 | Position field of the pending test |
| cmp_mask | output | 15 | Mask field of the pending test |
| cond_met | input | 1 | Comparator result |

## Verification
The bench targets the odd-slot rule across jumps, waits and skips. A sequencer that lost track of slot parity after a jump, or that fetched one cycle after the skip decision, would request in an even slot. Move words are written with junk in their high bits, and a design that did not mask them would write to the wrong register. Two strobes are fired in the same cycle, and a design with the priority inverted would start at the wrong list. A location register is loaded with an odd value, and a design that did not clear bit 0 would fetch from an odd address. A wait is interrupted by a jump, and a sequencer that ignored jumps while parked would stay stuck.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;
   typedef enum logic [1:0] {
      ST_FETCH1 = 2'd0,
      ST_FETCH2 = 2'd1,
      ST_WAIT   = 2'd2,
      ST_SKIP   = 2'd3
   } seq_st_t;

   localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/dlseq_slot.sv
module dlseq_slot #(
   parameter bit ODD_ONLY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_ok
);
   generate
      if (ODD_ONLY) begin : g_odd
         logic par_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) par_q <= 1'b0;
            else        par_q <= ~par_q;
         end
         assign slot_ok = par_q;

         // R2
         slot_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_ok |=> !slot_ok);
      end else begin : g_any
         assign slot_ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/dlseq_lcbank.sv
module dlseq_lcbank #(
   parameter int unsigned PC_W   = 18,
   parameter int unsigned NUM_LC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LC-1:0] lc_wr,
   input  logic [PC_W-1:0]   lc_wdata,
   input  logic [NUM_LC-1:0] jmp,
   input  logic              vblank,
   output logic              jump_take,
   output logic [PC_W-1:0]   jump_tgt
);
   logic [PC_W-1:0] lc_q [NUM_LC];

   for (genvar i = 0; i < NUM_LC; i++) begin : g_lc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       lc_q[i] <= '0;
         else if (lc_wr[i]) lc_q[i] <= lc_wdata;
      end
   end

   assign jump_take = (|jmp) | vblank;

   always_comb begin
      jump_tgt = lc_q[0];
      for (int k = NUM_LC - 1; k >= 0; k--) begin
         if (jmp[k]) jump_tgt = lc_q[k];
      end
      if (vblank) jump_tgt = lc_q[0];
   end

   // R11
   vblank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |-> (jump_take && jump_tgt == lc_q[0]));
endmodule

// File: rtl/dlseq_ctrl.sv
module dlseq_ctrl
   import dlseq_pkg::*;
#(
   parameter int unsigned      PC_W       = 18,
   parameter int unsigned      DW         = 16,
   parameter int unsigned      RA_W       = 9,
   parameter logic [RA_W-1:0]  MARK_ADDR  = 9'h08C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dma_en,
   input  logic            slot_ok,
   input  logic            jump_take,
   input  logic [PC_W-1:0] jump_tgt,
   input  logic            cond_met,
   input  logic [DW-1:0]   mem_rdata,
   output logic            mem_req,
   output logic [PC_W-1:0] mem_addr,
   output logic            reg_we,
   output logic [RA_W-1:0] reg_addr,
   output logic [DW-1:0]   reg_wdata,
   output logic            cmp_valid,
   output logic [DW-2:0]   cmp_pos,
   output logic [DW-2:0]   cmp_mask
);
   localparam logic [PC_W-1:0] STEP     = PC_W'(WORD_BYTES);
   localparam logic [PC_W-1:0] SKIP_ADV = PC_W'(2 * WORD_BYTES);
   localparam logic [PC_W-1:0] EVEN_MSK = {{(PC_W-1){1'b1}}, 1'b0};

   seq_st_t         st_q;
   logic [PC_W-1:0] pc_q;
   logic [DW-1:0]   ir1_q;
   logic [DW-2:0]   ir2_q;
   logic            fetch;
   logic            is_move;

   assign is_move = ~ir1_q[0];
   assign fetch   = dma_en && slot_ok && (st_q == ST_FETCH1 || st_q == ST_FETCH2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_FETCH1;
         pc_q  <= '0;
         ir1_q <= '0;
         ir2_q <= '0;
      end else if (jump_take) begin
         st_q <= ST_FETCH1;
         pc_q <= jump_tgt & EVEN_MSK;
      end else begin
         unique case (st_q)
            ST_FETCH1: if (fetch) begin
               ir1_q <= mem_rdata;
               pc_q  <= pc_q + STEP;
               st_q  <= ST_FETCH2;
            end
            ST_FETCH2: if (fetch) begin
               pc_q <= pc_q + STEP;
               if (is_move) begin
                  st_q <= ST_FETCH1;
               end else begin
                  ir2_q <= mem_rdata[DW-1:1];
                  st_q  <= mem_rdata[0] ? ST_SKIP : ST_WAIT;
               end
            end
            ST_WAIT: if (cond_met) st_q <= ST_FETCH1;
            ST_SKIP: begin
               if (cond_met) pc_q <= pc_q + SKIP_ADV;
               st_q <= ST_FETCH1;
            end
            default: st_q <= ST_FETCH1;
         endcase
      end
   end

   assign mem_req   = fetch;
   assign mem_addr  = pc_q;
   assign reg_we    = fetch && (st_q == ST_FETCH2) && is_move;
   assign reg_wdata = reg_we ? mem_rdata : '0;

   always_comb begin
      if (!fetch)      reg_addr = '0;
      else if (reg_we) reg_addr = {ir1_q[RA_W-1:1], 1'b0};
      else             reg_addr = MARK_ADDR;
   end

   assign cmp_valid = (st_q == ST_WAIT) || (st_q == ST_SKIP);
   assign cmp_pos   = ir1_q[DW-1:1];
   assign cmp_mask  = ir2_q;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> (!mem_req && !reg_we));
   // R4
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && !cond_met && !jump_take) |=> (st_q == ST_WAIT && !mem_req));
   // R10
   jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jump_take |=> (st_q == ST_FETCH1 && pc_q == ($past(jump_tgt) & EVEN_MSK)));
   // R12
   even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);
endmodule

// File: rtl/dlist_seq.sv
module dlist_seq #(
   parameter int unsigned      PC_W      = 18,
   parameter int unsigned      DW        = 16,
   parameter int unsigned      RA_W      = 9,
   parameter int unsigned      NUM_LC    = 2,
   parameter bit               ODD_ONLY  = 1'b1,
   parameter logic [RA_W-1:0]  MARK_ADDR = 9'h08C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_en,
   output logic              mem_req,
   output logic [PC_W-1:0]   mem_addr,
   input  logic [DW-1:0]     mem_rdata,
   output logic              reg_we,
   output logic [RA_W-1:0]   reg_addr,
   output logic [DW-1:0]     reg_wdata,
   input  logic [NUM_LC-1:0] lc_wr,
   input  logic [PC_W-1:0]   lc_wdata,
   input  logic [NUM_LC-1:0] jmp,
   input  logic              vblank,
   output logic              cmp_valid,
   output logic [DW-2:0]     cmp_pos,
   output logic [DW-2:0]     cmp_mask,
   input  logic              cond_met
);
   generate
      if (PC_W < 2)        begin : g_bad_pc  $error("PC_W must be at least 2"); end
      if (RA_W < 2 || RA_W > DW) begin : g_bad_ra $error("RA_W must lie in 2..DW"); end
      if (NUM_LC < 1)      begin : g_bad_lc  $error("NUM_LC must be at least 1"); end
   endgenerate

   logic            slot_ok;
   logic            jump_take;
   logic [PC_W-1:0] jump_tgt;

   dlseq_slot #(.ODD_ONLY(ODD_ONLY)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .slot_ok (slot_ok)
   );

   dlseq_lcbank #(.PC_W(PC_W), .NUM_LC(NUM_LC)) u_lc (
      .clk       (clk),
      .rst_n     (rst_n),
      .lc_wr     (lc_wr),
      .lc_wdata  (lc_wdata),
      .jmp       (jmp),
      .vblank    (vblank),
      .jump_take (jump_take),
      .jump_tgt  (jump_tgt)
   );

   dlseq_ctrl #(.PC_W(PC_W), .DW(DW), .RA_W(RA_W), .MARK_ADDR(MARK_ADDR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_en    (dma_en),
      .slot_ok   (slot_ok),
      .jump_take (jump_take),
      .jump_tgt  (jump_tgt),
      .cond_met  (cond_met),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .cmp_valid (cmp_valid),
      .cmp_pos   (cmp_pos),
      .cmp_mask  (cmp_mask)
   );

   generate
      if (ODD_ONLY) begin : g_gap_chk
         // R2
         req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |=> !mem_req);
      end
   endgenerate
   // R5
   mark_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !reg_we) |-> (reg_addr == MARK_ADDR));
endmodule

// File: tb/sim_dlist_seq.sv
module sim_dlist_seq;
   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_en = 1'b0;
   logic        mem_req;
   logic [17:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        reg_we;
   logic [8:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [1:0]  lc_wr = '0;
   logic [17:0] lc_wdata = '0;
   logic [1:0]  jmp = '0;
   logic        vblank = 1'b0;
   logic        cmp_valid;
   logic [14:0] cmp_pos;
   logic [14:0] cmp_mask;
   logic        cond_met;
   logic        cond_force = 1'b0;

   logic [15:0] mem [64];

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[6:1]];
   // bench comparator: position bit 0 means "always true", else follow cond_force
   assign cond_met = cmp_valid & (cmp_pos[0] | cond_force);

   dlist_seq u0 (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .lc_wr(lc_wr), .lc_wdata(lc_wdata), .jmp(jmp), .vblank(vblank),
      .cmp_valid(cmp_valid), .cmp_pos(cmp_pos), .cmp_mask(cmp_mask),
      .cond_met(cond_met)
   );

   // ---------------- monitor ----------------
   int          cyc;
   int          rq_n = 0;
   logic [17:0] rq_addr [256];
   int          wr_n = 0;
   logic [8:0]  wr_addr [256];
   logic [15:0] wr_data [256];
   int          wr_cyc  [256];
   int          bad_slot = 0;
   int          bad_mark = 0;
   int          bad_pulse = 0;
   int          bad_odd = 0;
   logic        prev_req = 1'b0;
   logic        prev_we = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) begin
            if ((cyc % 2) == 0 || prev_req) bad_slot++;
            if (mem_addr[0]) bad_odd++;
            if (!reg_we && reg_addr != 9'h08C) bad_mark++;
            rq_addr[rq_n % 256] = mem_addr;
            rq_n++;
         end
         if (reg_we) begin
            if (prev_we) bad_pulse++;
            wr_addr[wr_n % 256] = reg_addr;
            wr_data[wr_n % 256] = reg_wdata;
            wr_cyc[wr_n % 256]  = cyc;
            wr_n++;
         end
         prev_req = mem_req;
         prev_we  = reg_we;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_lc(input int idx, input logic [17:0] v);
      lc_wdata = v;
      lc_wr = 2'b01 << idx;
      tick(1);
      lc_wr = '0;
   endtask

   task automatic strobe(input logic [1:0] j);
      jmp = j;
      tick(1);
      jmp = '0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_idle();
      int base;
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(!mem_req && !reg_we, "R1 reset outputs", {mem_req, reg_we}, 0);
      load_lc(0, 18'h00000);
      load_lc(1, 18'h00020);
      strobe(2'b01);
      base = rq_n;
      tick(20);
      chk(rq_n == base, "R1 no fetch while dma_en low", rq_n - base, 0);
   endtask

   task automatic t_move_wait();
      int wb, rb;
      wb = wr_n; rb = rq_n;
      dma_en = 1'b1;
      tick(60);
      chk(rq_addr[rb % 256] == 18'h0, "R10 first fetch from location 0", rq_addr[rb % 256], 0);
      chk(wr_n - wb == 2, "R7 two moves then parked", wr_n - wb, 2);
      chk(wr_addr[wb % 256] == 9'h040, "R4 high bits ignored in dest", wr_addr[wb % 256], 9'h040);
      chk(wr_data[wb % 256] == 16'h1111, "R4 move data", wr_data[wb % 256], 16'h1111);
      chk(wr_addr[(wb+1) % 256] == 9'h042 && wr_data[(wb+1) % 256] == 16'h2222,
          "R3 second move", wr_data[(wb+1) % 256], 16'h2222);
      chk(wr_cyc[(wb+1) % 256] - wr_cyc[wb % 256] == 4, "R6 move spacing",
          wr_cyc[(wb+1) % 256] - wr_cyc[wb % 256], 4);
      chk(cmp_valid && cmp_pos == 15'h0000 && cmp_mask == 15'h7FFF, "R7 comparator fields",
          {cmp_valid, cmp_pos, cmp_mask}, {1'b1, 15'h0000, 15'h7FFF});
      rb = rq_n;
      tick(30);
      chk(rq_n == rb, "R7 off bus while waiting", rq_n - rb, 0);
      cond_force = 1'b1;
      tick(1);
      cond_force = 1'b0;
      tick(40);
      chk(wr_n - wb == 3 && wr_addr[(wb+2) % 256] == 9'h044 && wr_data[(wb+2) % 256] == 16'h3333,
          "R7 resumes after match", wr_data[(wb+2) % 256], 16'h3333);
      chk(rq_addr[(rq_n-1) % 256] == 18'h12, "R6 pc steps by 2", rq_addr[(rq_n-1) % 256], 18'h12);
   endtask

   task automatic t_skip_met();
      int wb, rb;
      wb = wr_n; rb = rq_n;
      strobe(2'b10);
      tick(60);
      chk(rq_addr[rb % 256] == 18'h20, "R10 jump 1 aborts wait", rq_addr[rb % 256], 18'h20);
      chk(wr_n - wb == 1, "R8 one write after skip", wr_n - wb, 1);
      chk(wr_addr[wb % 256] == 9'h048 && wr_data[wb % 256] == 16'h5555, "R8 skipped instruction",
          wr_data[wb % 256], 16'h5555);
   endtask

   task automatic t_skip_not_prio();
      int wb, rb;
      load_lc(0, 18'h00030);
      wb = wr_n; rb = rq_n;
      strobe(2'b11);
      tick(60);
      chk(rq_addr[rb % 256] == 18'h30, "R10 lowest strobe wins", rq_addr[rb % 256], 18'h30);
      chk(wr_n - wb == 1 && wr_addr[wb % 256] == 9'h04A && wr_data[wb % 256] == 16'h6666,
          "R9 no skip when unmet", wr_data[wb % 256], 16'h6666);
   endtask

   task automatic t_vblank();
      int wb, rb;
      load_lc(0, 18'h00031);
      wb = wr_n; rb = rq_n;
      vblank = 1'b1;
      tick(1);
      vblank = 1'b0;
      tick(60);
      chk(rq_addr[rb % 256] == 18'h30, "R11 R12 vblank reload even", rq_addr[rb % 256], 18'h30);
      chk(wr_n - wb == 1 && wr_data[wb % 256] == 16'h6666, "R11 list rerun", wr_n - wb, 1);
   endtask

   task automatic t_dma_off();
      int rb;
      dma_en = 1'b0;
      strobe(2'b10);
      rb = rq_n;
      tick(30);
      chk(rq_n == rb, "R1 dma_en low blocks fetch", rq_n - rb, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      // list A at 0x00
      mem[0]  = 16'hFE40; mem[1]  = 16'h1111;
      mem[2]  = 16'h0042; mem[3]  = 16'h2222;
      mem[4]  = 16'h0001; mem[5]  = 16'hFFFE;
      mem[6]  = 16'h0044; mem[7]  = 16'h3333;
      mem[8]  = 16'h0001; mem[9]  = 16'hFFFE;
      // list B at 0x20: skip (met), move, move, park
      mem[16] = 16'h0003; mem[17] = 16'hFFFF;
      mem[18] = 16'h0046; mem[19] = 16'h4444;
      mem[20] = 16'h0048; mem[21] = 16'h5555;
      mem[22] = 16'h0001; mem[23] = 16'hFFFE;
      // list C at 0x30: skip (unmet), move, park
      mem[24] = 16'h0001; mem[25] = 16'hFFFF;
      mem[26] = 16'h004A; mem[27] = 16'h6666;
      mem[28] = 16'h0001; mem[29] = 16'hFFFE;

      t_reset_idle();
      t_move_wait();
      t_skip_met();
      t_skip_not_prio();
      t_vblank();
      t_dma_off();

      chk(bad_slot == 0, "R2 odd slots only", bad_slot, 0);
      chk(bad_mark == 0, "R5 marker address on fetch", bad_mark, 0);
      chk(bad_pulse == 0, "R4 single-cycle strobe", bad_pulse, 0);
      chk(bad_odd == 0, "R12 even fetch addresses", bad_odd, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule